// File: doc/BRIEF.md
# Parallel Microprocessor Slave Port

This block lets an external 8-bit microprocessor use a data latch pair inside the chip as if it were an ordinary bus peripheral. The external side has an active-low chip select, an active-low read strobe and an active-low write strobe, plus a tri-stateable data bus. That bus is split here into an input, an output and an output enable for the pad ring. The internal host side works on the system clock. It loads the outgoing latch, reads the incoming latch, watches handshake flags and services an interrupt.

The external strobes are asynchronous. Each one passes through a multi-flop synchronizer. A transfer is recognised on the first synchronized sample in which chip select and the matching strobe are both low. An external write captures the bus into the incoming latch once for each strobe assertion and sets the input-full flag. An external read marks the outgoing latch as consumed when the strobe ends. Both kinds of transfer raise a sticky interrupt flag. The port responds only while the mode enable is set and all three control-pin direction bits select input.

Top module: `upar_slave_port`

## Requirements
- R1: After reset, `in_data`, `ibf`, `obf`, `ovf` and `irq` are all 0 and `ext_d_oe` is 0.
- R2: An external write is taken on the first synchronized sample in which `ext_cs_n` and `ext_wr_n` are both low. With SYNC_STAGES=2, the value on `ext_d_i` appears on `in_data` after the third rising clock edge that follows the assertion.
- R3: A write strobe held low captures only once. Bus changes during the same assertion leave `in_data` unchanged.
- R4: `ibf` is set by a captured external write and cleared by a `host_rd` pulse. When a capture and `host_rd` fall in the same cycle, the capture wins.
- R5: An external write captured while `ibf` is already 1 sets `ovf`. `ovf` stays set until an `ovf_clr` pulse.
- R6: A `host_wr` pulse loads `host_wdata` into the outgoing latch and sets `obf`. `obf` clears on the third clock edge after the external read condition (chip select and read strobe both low) is released.
- R7: `ext_d_oe` is 1, and `ext_d_o` carries the outgoing latch, exactly while `ext_cs_n` and `ext_rd_n` are both low and the port is enabled. The output enable is combinational from the pins.
- R8: Every recognised external read or write sets `irq` on the third edge after the strobe assertion. `irq` stays set until an `irq_clr` pulse, and a transfer in the same cycle as `irq_clr` wins.
- R9: While `mode_en` is 0, or any bit of `ctl_dir` (bit 0 read, bit 1 write, bit 2 chip select; 1 means input) is 0, strobes are ignored: `in_data`, `ibf`, `obf`, `ovf` and `irq` stay unchanged and `ext_d_oe` stays 0.
- R10: A write or read strobe with `ext_cs_n` high causes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_cs_n | input | 1 | External chip select, active low, asynchronous |
| ext_rd_n | input | 1 | External read strobe, active low, asynchronous |
| ext_wr_n | input | 1 | External write strobe, active low, asynchronous |
| ext_d_i | input | DATA_W | Data from the external bus |
| ext_d_o | output | DATA_W | Data toward the external bus |
| ext_d_oe | output | 1 | Drive enable for the external bus pads |
| mode_en | input | 1 | Slave port mode enable |
| ctl_dir | input | 3 | Direction bits of the control pins, 1 = input |
| host_wr | input | 1 | Load pulse for the outgoing latch |
| host_wdata | input | DATA_W | Data for the outgoing latch |
| host_rd | input | 1 | Read acknowledge pulse for the incoming latch |
| in_data | output | DATA_W | Incoming latch contents |
| ibf | output | 1 | Input-buffer-full flag |
| obf | output | 1 | Output-buffer-full flag |
| ovf | output | 1 | Input overflow flag |
| ovf_clr | input | 1 | Clear pulse for `ovf` |
| irq | output | 1 | Sticky transfer interrupt flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |

## Verification
Directed sequences come first. Each puts a single write strobe, a single read strobe, or a strobe without chip select on the port. These separate the three-edge capture latency and the held-strobe single capture from a design that samples on level, and they show that chip select gates every transfer. Two same-cycle collisions follow: capture against `host_rd`, and transfer against `irq_clr`. They show which side wins.

A seeded random mix of external writes, external reads, host loads, host reads, flag clears and disabled-port strobes then runs against a bench model. It separates correct overflow and buffer-full bookkeeping from flags that miss a sequence, and it confirms that a disabled port holds all state and never drives the bus.

// File: rtl/upsp_pkg.sv
`timescale 1ns/1ps
package upsp_pkg;
   // bit positions inside the control-pin direction vector
   localparam int DIR_RD = 0;
   localparam int DIR_WR = 1;
   localparam int DIR_CS = 2;
   localparam int DIR_W  = 3;

   typedef struct packed {
      logic cs_n;
      logic rd_n;
      logic wr_n;
   } strobe_t;
endpackage

// File: rtl/upsp_sync.sv
`timescale 1ns/1ps
module upsp_sync #(
   parameter int         W        = 3,
   parameter int         STAGES   = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("upsp_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("upsp_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/upsp_edge.sv
`timescale 1ns/1ps
module upsp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise,
   output logic fall
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
   assign fall = ~level & level_q;

   // R3: an event pulse never lasts two cycles
   p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/upsp_flags.sv
`timescale 1ns/1ps
module upsp_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              rd_start,
   input  logic              rd_end,
   input  logic [DATA_W-1:0] ext_d_i,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   input  logic              ovf_clr,
   input  logic              irq_clr,
   output logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] out_data,
   output logic              ibf,
   output logic              obf,
   output logic              ovf,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_data  <= '0;
         out_data <= '0;
         ibf      <= 1'b0;
         obf      <= 1'b0;
         ovf      <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (wr_start) in_data <= ext_d_i;
         if (host_wr)  out_data <= host_wdata;

         if (wr_start)     ibf <= 1'b1;
         else if (host_rd) ibf <= 1'b0;

         if (wr_start && ibf) ovf <= 1'b1;
         else if (ovf_clr)    ovf <= 1'b0;

         if (host_wr)     obf <= 1'b1;
         else if (rd_end) obf <= 1'b0;

         if (wr_start || rd_start) irq <= 1'b1;
         else if (irq_clr)         irq <= 1'b0;
      end
   end

   p_ibf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> ibf);
   p_ibf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !wr_start) |=> !ibf);
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && ibf) |=> ovf);
   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);
   p_obf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && !host_wr) |=> !obf);
   p_irq_on_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start || rd_start) |=> irq);
   p_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_start |=> $stable(in_data));
endmodule

// File: rtl/upar_slave_port.sv
`timescale 1ns/1ps
module upar_slave_port
   import upsp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_cs_n,
   input  logic              ext_rd_n,
   input  logic              ext_wr_n,
   input  logic [DATA_W-1:0] ext_d_i,
   output logic [DATA_W-1:0] ext_d_o,
   output logic              ext_d_oe,
   input  logic              mode_en,
   input  logic [DIR_W-1:0]  ctl_dir,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] in_data,
   output logic              ibf,
   output logic              obf,
   output logic              ovf,
   input  logic              ovf_clr,
   output logic              irq,
   input  logic              irq_clr
);
   localparam int STB_W = $bits(strobe_t);

   if (DATA_W < 1) begin : g_bad_dw
      $error("upar_slave_port: DATA_W must be positive");
   end

   strobe_t raw_stb, syn_stb;
   logic    port_on;
   logic    wr_act, rd_act;
   logic    wr_rise, wr_fall_unused, rd_rise, rd_fall;
   logic    wr_start, rd_start, rd_end;

   assign raw_stb = '{cs_n: ext_cs_n, rd_n: ext_rd_n, wr_n: ext_wr_n};
   assign port_on = mode_en & ctl_dir[DIR_RD] & ctl_dir[DIR_WR] & ctl_dir[DIR_CS];

   upsp_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_stb),
      .d_sync  (syn_stb)
   );

   assign wr_act = ~syn_stb.cs_n & ~syn_stb.wr_n;
   assign rd_act = ~syn_stb.cs_n & ~syn_stb.rd_n;

   upsp_edge u_wr_edge (
      .clk (clk), .rst_n (rst_n), .level (wr_act),
      .rise (wr_rise), .fall (wr_fall_unused)
   );
   upsp_edge u_rd_edge (
      .clk (clk), .rst_n (rst_n), .level (rd_act),
      .rise (rd_rise), .fall (rd_fall)
   );

   assign wr_start = wr_rise & port_on;
   assign rd_start = rd_rise & port_on;
   assign rd_end   = rd_fall & port_on;

   upsp_flags #(.DATA_W(DATA_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start   (wr_start),
      .rd_start   (rd_start),
      .rd_end     (rd_end),
      .ext_d_i    (ext_d_i),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rd    (host_rd),
      .ovf_clr    (ovf_clr),
      .irq_clr    (irq_clr),
      .in_data    (in_data),
      .out_data   (ext_d_o),
      .ibf        (ibf),
      .obf        (obf),
      .ovf        (ovf),
      .irq        (irq)
   );

   assign ext_d_oe = port_on & ~ext_cs_n & ~ext_rd_n;

   // R9: a disabled port with no host activity keeps every flag
   p_hold_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_on && !host_wr && !host_rd && !ovf_clr && !irq_clr)
      |=> ($stable(ibf) && $stable(obf) && $stable(ovf) && $stable(irq)
           && $stable(in_data)));
   // R7 / R10: no drive without chip select
   p_no_drive_cs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cs_n |-> !ext_d_oe);
   // R10: a write without chip select leaves the incoming latch alone
   p_cs_needed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_stb.cs_n && !host_rd) |=> ($stable(in_data) && $stable(ibf)));
endmodule

// File: tb/upar_slave_port_tb.sv
`timescale 1ns/1ps
module upar_slave_port_tb_top;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [DW-1:0] d_in = '0;
   logic [DW-1:0] d_out;
   logic          d_oe;
   logic          mode_en = 1'b1;
   logic [2:0]    ctl_dir = 3'b111;
   logic          host_wr = 1'b0, host_rd = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] in_data;
   logic          ibf, obf, ovf, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   logic [DW-1:0] m_in = '0, m_out = '0;
   bit m_ibf = 0, m_obf = 0, m_ovf = 0, m_irq = 0;

   always #2.5 clk = ~clk;

   upar_slave_port #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .ext_cs_n (cs_n), .ext_rd_n (rd_n), .ext_wr_n (wr_n),
      .ext_d_i (d_in), .ext_d_o (d_out), .ext_d_oe (d_oe),
      .mode_en (mode_en), .ctl_dir (ctl_dir),
      .host_wr (host_wr), .host_wdata (host_wdata), .host_rd (host_rd),
      .in_data (in_data), .ibf (ibf), .obf (obf), .ovf (ovf),
      .ovf_clr (ovf_clr), .irq (irq), .irq_clr (irq_clr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "in_data", int'(in_data), int'(m_in));
      chk(req, "ibf", int'(ibf), int'(m_ibf));
      chk(req, "obf", int'(obf), int'(m_obf));
      chk(req, "ovf", int'(ovf), int'(m_ovf));
      chk(req, "irq", int'(irq), int'(m_irq));
      chk(req, "oe_idle", int'(d_oe), 0);
   endtask

   function automatic bit enabled();
      return mode_en && (&ctl_dir);
   endfunction

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // external write; data changes while held to test single capture
   task automatic ext_write(input logic [DW-1:0] v, input bit use_cs);
      bit on;
      on = enabled() && use_cs;
      d_in = v; wr_n = 1'b0; cs_n = !use_cs;
      cyc(3);
      if (on) begin
         if (m_ibf) m_ovf = 1;
         m_ibf = 1; m_irq = 1; m_in = v;
      end
      chk(use_cs ? "R2" : "R10", "in_data after write", int'(in_data), int'(m_in));
      d_in = ~v;
      cyc(2);
      chk("R3", "in_data held strobe", int'(in_data), int'(m_in));
      wr_n = 1'b1; cs_n = 1'b1;
      cyc(3);
   endtask

   task automatic ext_read(input bit use_cs);
      bit on;
      on = enabled() && use_cs;
      rd_n = 1'b0; cs_n = !use_cs;
      #1;
      chk(on ? "R7" : "R9", "oe during read", int'(d_oe), int'(on));
      if (on) chk("R7", "bus data", int'(d_out), int'(m_out));
      cyc(3);
      if (on) m_irq = 1;
      chk("R8", "irq after read", int'(irq), int'(m_irq));
      rd_n = 1'b1; cs_n = 1'b1;
      #1;
      chk("R7", "oe released", int'(d_oe), 0);
      cyc(3);
      if (on) m_obf = 0;
      chk("R6", "obf after read end", int'(obf), int'(m_obf));
   endtask

   task automatic pulse_host_wr(input logic [DW-1:0] v);
      host_wr = 1'b1; host_wdata = v;
      cyc(1);
      host_wr = 1'b0;
      m_out = v; m_obf = 1;
   endtask

   task automatic pulse_host_rd();
      host_rd = 1'b1; cyc(1); host_rd = 1'b0;
      m_ibf = 0;
   endtask

   task automatic pulse_irq_clr();
      irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
      m_irq = 0;
   endtask

   task automatic pulse_ovf_clr();
      ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
      m_ovf = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      cyc(3);
      // R1 reset state
      chk_all("R1");
      rst_n = 1'b1;
      cyc(2);
      chk_all("R1");

      // R2 / R3 / R4 basic write and host read
      ext_write(8'hA5, 1'b1);
      chk_all("R4");
      pulse_host_rd();
      chk_all("R4");
      // R5 overflow
      ext_write(8'h3C, 1'b1);
      ext_write(8'hC3, 1'b1);
      chk_all("R5");
      pulse_ovf_clr();
      pulse_host_rd();
      pulse_irq_clr();
      chk_all("R5");
      // R10 write without chip select
      ext_write(8'h77, 1'b0);
      chk_all("R10");
      // R6 / R7 host load and external read
      pulse_host_wr(8'h5A);
      chk_all("R6");
      ext_read(1'b1);
      chk_all("R6");
      pulse_irq_clr();

      // R4 collision: capture against host_rd, capture wins
      d_in = 8'h11; wr_n = 1'b0; cs_n = 1'b0;
      cyc(2);
      host_rd = 1'b1; irq_clr = 1'b1;
      cyc(1);
      host_rd = 1'b0; irq_clr = 1'b0;
      m_in = 8'h11; m_ibf = 1; m_irq = 1;
      chk("R4", "ibf capture beats host_rd", int'(ibf), 1);
      chk("R8", "irq transfer beats clear", int'(irq), 1);
      wr_n = 1'b1; cs_n = 1'b1;
      cyc(3);
      chk_all("R8");

      // R9 disabled port
      mode_en = 1'b0;
      pulse_host_wr(8'h99);
      ext_write(8'hEE, 1'b1);
      ext_read(1'b1);
      chk_all("R9");
      mode_en = 1'b1; ctl_dir = 3'b101;
      ext_write(8'hDD, 1'b1);
      ext_read(1'b1);
      chk_all("R9");
      ctl_dir = 3'b111;

      // random mix
      for (int it = 0; it < 60; it++) begin
         int op;
         op = int'($urandom % 8);
         case (op)
            0, 1: ext_write(DW'($urandom), 1'b1);
            2:    ext_read(1'b1);
            3:    pulse_host_wr(DW'($urandom));
            4:    pulse_host_rd();
            5:    pulse_irq_clr();
            6:    pulse_ovf_clr();
            default: begin
               if ($urandom % 2 == 0) mode_en = 1'b0;
               else ctl_dir = 3'(1 << ($urandom % 3)) ^ 3'b111;
               if ($urandom % 2 == 0) ext_write(DW'($urandom), 1'b1);
               else ext_read(1'b1);
               mode_en = 1'b1; ctl_dir = 3'b111;
            end
         endcase
         chk_all(op == 7 ? "R9" : "R4");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule